// File: doc/BRIEF.md
# Two-Digit Decimal Press Counter with Segment Outputs

This block counts button presses from 00 to 99 and shows the count on two seven-segment digits. It takes two raw push-button levels, one to advance and one to clear. Each level first passes a stability filter. The filtered advance level is then turned into a single-cycle pulse on its rising edge.

The count is held as two decimal digits. The low digit steps on every pulse. The high digit steps only when the low digit rolls over from 9, so the pair wraps from 99 to 00. Each digit drives a combinational decoder that lights segments active-high. Any digit code above 9 is shown as the letter E. The raw digit values are also brought out for observation.

Top module: `press_counter_7seg`

## Requirements
- R1: After the reset input rst_ni goes low, both digits read 0, and the debounced button states are low.
- R2: A raw button level is accepted only after it has been unchanged for STABLE_CYCLES consecutive clock cycles. A bounce shorter than that has no effect on the count.
- R3: Each accepted rising edge of the advance button increases the count by exactly one. Holding the button down gives no further increments.
- R4: The low digit runs 0..9. On a pulse while it is 9, it returns to 0 and the high digit increments.
- R5: On a pulse at count 99, both digits return to 0.
- R6: An accepted high level on the clear button sets both digits to 0 on the next clock edge. Clear takes priority over a simultaneous advance pulse.
- R7: Segment bit 0 is a, bit 1 is b, and so on up to bit 6 for g; a 1 lights the segment. The patterns for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R8: A digit code from 10 to 15 drives the pattern 0x79, which is the letter E (a, d, e, f, g).
- R9: A digit value never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_inc_i | input | 1 | Raw advance button level |
| btn_clr_i | input | 1 | Raw clear button level |
| seg_lo_o | output | 7 | Segment pattern for the low digit |
| seg_hi_o | output | 7 | Segment pattern for the high digit |
| digit_lo_o | output | 4 | Low digit value |
| digit_hi_o | output | 4 | High digit value |

## Verification
The assertions assume that the button inputs are sampled synchronously. They also assume that a pulse and a clear can arrive together, and they give clear priority in that case. The stimulus changes buttons only on falling clock edges. Each press or release is held well beyond STABLE_CYCLES, with a small STABLE_CYCLES set on the bench. Bounce bursts are deliberately shorter than the filter window. Every digit pattern, including the error codes, is also swept through a separately instantiated decoder.

// File: rtl/press_counter_pkg.sv
package press_counter_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
  localparam logic [SEG_W-1:0]   SEG_ERR   = 7'h79;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic             sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      cnt_q   <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q <= raw_i;
      if (sync_q == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        level_o <= sync_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // r2: accepted level only changes after a full stable window
  a_r2_change_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end
  assign pulse_o = level_i & ~prev_q;

  // R3: one pulse per press
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import press_counter_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  output logic [DIGIT_W-1:0] value_o,
  output logic               carry_o
);
  assign carry_o = step_i && (value_o == DIGIT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_o <= '0;
    else if (clr_i)   value_o <= '0;
    else if (carry_o) value_o <= '0;
    else if (step_i)  value_o <= value_o + 1'b1;
  end

  a_r9_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    value_o <= DIGIT_MAX);
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && value_o == DIGIT_MAX) |=> (value_o == '0));
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (value_o == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(value_o));
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import press_counter_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SEG_W-1:0]   seg_o
);
  // bit0=a .. bit6=g, active high
  always_comb begin
    unique case (digit_i)
      4'd0: seg_o = 7'h3F;
      4'd1: seg_o = 7'h06;
      4'd2: seg_o = 7'h5B;
      4'd3: seg_o = 7'h4F;
      4'd4: seg_o = 7'h66;
      4'd5: seg_o = 7'h6D;
      4'd6: seg_o = 7'h7D;
      4'd7: seg_o = 7'h07;
      4'd8: seg_o = 7'h7F;
      4'd9: seg_o = 7'h6F;
      default: seg_o = SEG_ERR;
    endcase
  end

  always_comb begin
    a_r8_err_glyph: assert ((digit_i <= DIGIT_MAX) || (seg_o == SEG_ERR));
  end
endmodule

// File: rtl/press_counter_7seg.sv
module press_counter_7seg
  import press_counter_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               btn_inc_i,
  input  logic               btn_clr_i,
  output logic [SEG_W-1:0]   seg_lo_o,
  output logic [SEG_W-1:0]   seg_hi_o,
  output logic [DIGIT_W-1:0] digit_lo_o,
  output logic [DIGIT_W-1:0] digit_hi_o
);
  logic inc_lvl, clr_lvl, inc_pulse, lo_carry, hi_carry;

  btn_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_flt_inc (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(btn_inc_i), .level_o(inc_lvl));
  btn_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_flt_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(btn_clr_i), .level_o(clr_lvl));

  rise_pulse u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(inc_lvl), .pulse_o(inc_pulse));

  bcd_digit u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_lvl), .step_i(inc_pulse),
    .value_o(digit_lo_o), .carry_o(lo_carry));
  bcd_digit u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_lvl), .step_i(lo_carry),
    .value_o(digit_hi_o), .carry_o(hi_carry));

  seg_decoder u_dec_lo (.digit_i(digit_lo_o), .seg_o(seg_lo_o));
  seg_decoder u_dec_hi (.digit_i(digit_hi_o), .seg_o(seg_hi_o));

  // R5: 99 -> 00
  a_r5_full_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_carry && !clr_lvl) |=> (digit_lo_o == '0 && digit_hi_o == '0));
  // R4: tens step only with units rollover
  a_r4_tens_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_hi_o != $past(digit_hi_o) && !$past(clr_lvl)) |-> ($past(digit_lo_o) == DIGIT_MAX && digit_lo_o == '0));
endmodule

// File: tb/press_counter_7seg_tb_top.sv
module press_counter_7seg_tb_top;
  localparam int STAB = 4;
  logic clk = 0, rst_ni = 0, inc = 0, clr = 0;
  logic [6:0] seg_lo, seg_hi, dseg;
  logic [3:0] d_lo, d_hi, dsw;
  int checks = 0, fails = 0, exp_cnt = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  press_counter_7seg #(.STABLE_CYCLES(STAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .btn_inc_i(inc), .btn_clr_i(clr),
    .seg_lo_o(seg_lo), .seg_hi_o(seg_hi), .digit_lo_o(d_lo), .digit_hi_o(d_hi));
  seg_decoder u_sweep (.digit_i(dsw), .seg_o(dseg));

  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] t [10] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,7'h7F,7'h6F};
    return (d < 10) ? t[d] : 7'h79;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_count(input string req);
    chk(req, d_lo, exp_cnt % 10);
    chk(req, d_hi, exp_cnt / 10);
    chk("R7", seg_lo, exp_seg(exp_cnt % 10));
    chk("R7", seg_hi, exp_seg(exp_cnt / 10));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    inc = 1; wait_cyc(STAB + 4);
    inc = 0; wait_cyc(STAB + 4);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk("R1", d_lo, 0); chk("R1", d_hi, 0);
    rst_ni = 1; wait_cyc(2);
    chk_count("R1");
    for (int d = 0; d < 16; d++) begin
      dsw = 4'(d); #1;
      chk(d < 10 ? "R7" : "R8", dseg, exp_seg(d));
    end
    // R2: short bounces ignored
    for (int k = 0; k < 3; k++) begin
      inc = 1; wait_cyc(STAB - 1); inc = 0; wait_cyc(2);
    end
    wait_cyc(STAB + 2);
    chk_count("R2");
    // R3: held button counts once
    inc = 1; wait_cyc(STAB * 10); exp_cnt = 1;
    chk_count("R3");
    inc = 0; wait_cyc(STAB + 4);
    chk_count("R3");
    // R4/R5: sweep through 99 -> 00
    for (int p = 0; p < 100; p++) begin
      press(); exp_cnt = (exp_cnt + 1) % 100;
      chk_count(exp_cnt == 0 ? "R5" : (exp_cnt % 10 == 0 ? "R4" : "R3"));
    end
    for (int p = 0; p < 23; p++) begin press(); exp_cnt++; end
    chk_count("R4");
    // R6: clear
    clr = 1; wait_cyc(STAB + 4); exp_cnt = 0;
    chk_count("R6");
    // R6: clear wins over advance while held
    inc = 1; wait_cyc(STAB + 4);
    chk_count("R6");
    inc = 0; clr = 0; wait_cyc(STAB + 4);
    chk_count("R6");
    press(); exp_cnt = 1;
    chk_count("R3");
    // R1: reset mid-count
    rst_ni = 0; wait_cyc(1); rst_ni = 1; exp_cnt = 0;
    wait_cyc(1);
    chk_count("R1");
    chk("R9", int'(d_lo <= 9 && d_hi <= 9), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule